// File: doc/BRIEF.md
# Multi-Block SD Transfer Session Controller

This controller sits between a sector-level read/write request port and the lower layers of an SD host: a command engine that sends one command and collects its response, and two data-block movers, one receiving and one transmitting. It keeps a multiple-block read or write open on the card after a request is served. A later request can then reuse that open transfer when it names the next sector in the same direction. In that case no command is needed, and only one more data block is moved.

Any other request first closes the open transfer with a stop command. It then opens a new multiple-block read or write at the requested sector, and the first data block follows. For standard-capacity cards the command argument is a byte address, and for high-capacity cards it is the sector number. A flush input closes any open transfer so that the card is left idle. The controller serves one request or flush at a time. It holds its ready output low until the stop command, the open command and the data block of that operation have all completed.

Top module: `sdx_session_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1 and cmd_valid, rx_start, tx_start and req_done are 0. After reset no transfer is considered open, so a request for any sector opens a new one.
- R2: With no transfer open, a read request issues command index 18. After cmd_ack, rx_start is high for exactly one cycle. After rx_done, req_done is high for exactly one cycle.
- R3: With a read open, a read request for the last sector plus 1 issues no command. It raises rx_start directly and later req_done.
- R4: With a write open, a write request for the last sector plus 1 issues no command. It raises tx_start directly and later req_done.
- R5: Opening a write issues command index 25, which carries a response only. The block is sent by a separate one-cycle tx_start after cmd_ack, and req_done follows tx_done.
- R6: While a transfer is open, any request that does not qualify for reuse (different direction, or a sector other than last plus 1) first issues command index 12 with argument 0 and cmd_tail 0x61. The open command for the new transfer follows.
- R7: The open command's argument is the sector shifted left by 9 and truncated to 32 bits when card_hc is 0, and the sector unchanged when card_hc is 1. Its cmd_tail is 0x00.
- R8: req_ready is 0 from the cycle after a request or flush is accepted through its req_done cycle. Requests presented in that window are ignored.
- R9: flush_req, which wins over req_valid, issues the stop command when a transfer is open and then pulses req_done. With nothing open it pulses req_done with no command. Afterwards nothing is open, so even the next consecutive sector opens a new transfer without a stop.
- R10: cmd_valid stays high with cmd_index and cmd_arg unchanged until the cycle in which cmd_ack is sampled.
- R11: The last sector is updated on every served request, whether it was streamed or newly opened. The last-plus-1 comparison wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sector request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sector | input | 32 | Requested sector number |
| card_hc | input | 1 | Card uses sector addressing (high capacity) |
| flush_req | input | 1 | Close any open transfer |
| req_ready | output | 1 | Controller idle; request or flush accepted this cycle |
| req_done | output | 1 | One-cycle completion strobe |
| cmd_valid | output | 1 | Command request to the command engine |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_tail | output | 8 | Fixed final byte for the stop command, 0 otherwise |
| cmd_ack | input | 1 | Command engine finished the command and response |
| rx_start | output | 1 | Start receiving one data block |
| rx_done | input | 1 | Receive mover finished its block |
| tx_start | output | 1 | Start transmitting one data block |
| tx_done | input | 1 | Transmit mover finished its block |

## Verification
The assertions assume a well-behaved lower layer. cmd_ack arrives only while cmd_valid is high. rx_done or tx_done arrives only after the matching start strobe, and once per block. Request inputs change only while the controller is idle, or are ignored while it is busy. The bench's responder model follows these rules. It acknowledges each command after a fixed delay and answers each start strobe with a single done pulse one cycle later. The only busy-time stimulus it applies is a deliberately ignored request.

// File: rtl/sdx_pkg.sv
// Shared definitions for the SD multi-block session controller.
// Assumes a 6-bit command index as used by the SD command layer.
package sdx_pkg;
    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] CMD_STOP     = 6'd12;
    localparam logic [CMD_W-1:0] CMD_RD_MULTI = 6'd18;
    localparam logic [CMD_W-1:0] CMD_WR_MULTI = 6'd25;
    localparam logic [7:0]       STOP_TAIL    = 8'h61;

    typedef enum logic [1:0] {
        SESS_NONE  = 2'd0,
        SESS_READ  = 2'd1,
        SESS_WRITE = 2'd2
    } sess_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STOP  = 3'd1,
        ST_OPEN  = 3'd2,
        ST_XGO   = 3'd3,
        ST_XWAIT = 3'd4,
        ST_DONE  = 3'd5
    } fsm_e;
endpackage

// File: rtl/sdx_addr_map.sv
// Converts a sector number into a command argument.
// Standard-capacity cards take a byte address (sector << BLOCK_SHIFT,
// truncated to the sector width); high-capacity cards take the sector.
module sdx_addr_map #(
    parameter int SECTOR_W    = 32,
    parameter int BLOCK_SHIFT = 9
) (
    input  logic [SECTOR_W-1:0] sector,
    input  logic                hc,
    output logic [SECTOR_W-1:0] arg
);
    localparam int WIDE_W = SECTOR_W + BLOCK_SHIFT;

    logic [SECTOR_W-1:0] byte_addr;

    // Build the byte address; a zero shift degenerates to a wire.
    generate
        if (BLOCK_SHIFT == 0) begin : g_noshift
            assign byte_addr = sector;
        end else begin : g_shift
            logic [WIDE_W-1:0] wide;
            assign wide      = {sector, {BLOCK_SHIFT{1'b0}}};
            assign byte_addr = wide[SECTOR_W-1:0];
        end
    endgenerate

    // Select the addressing mode of the card.
    always_comb begin
        arg = hc ? sector : byte_addr;
    end
endmodule

// File: rtl/sdx_seq_match.sv
// Decides whether a request can reuse the open transfer: same direction
// and sector equal to the last served sector plus one (modulo 2^SECTOR_W).
module sdx_seq_match
    import sdx_pkg::*;
#(
    parameter int SECTOR_W = 32
) (
    input  sess_e               session,
    input  logic                req_write,
    input  logic [SECTOR_W-1:0] req_sector,
    input  logic [SECTOR_W-1:0] last_sector,
    output logic                hit
);
    logic [SECTOR_W-1:0] next_sector;
    logic                dir_ok;

    // Compare direction and successor sector.
    always_comb begin
        next_sector = last_sector + {{(SECTOR_W-1){1'b0}}, 1'b1};
        dir_ok      = req_write ? (session == SESS_WRITE) : (session == SESS_READ);
        hit         = dir_ok && (req_sector == next_sector);
    end
endmodule

// File: rtl/sdx_session_fsm.sv
// Sequencer for one request or flush: optional stop command, optional
// open command, optional data block, then a done strobe. Holds the open
// session kind and the last served sector. Assumes the lower layers
// acknowledge only what they were asked for.
module sdx_session_fsm
    import sdx_pkg::*;
#(
    parameter int SECTOR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [SECTOR_W-1:0] req_sector,
    input  logic                card_hc,
    input  logic                flush_req,
    input  logic                hit,
    input  logic                cmd_ack,
    input  logic                rx_done,
    input  logic                tx_done,
    output sess_e               session,
    output logic [SECTOR_W-1:0] last_sector,
    output logic [SECTOR_W-1:0] op_sector,
    output logic                op_hc,
    output logic                req_ready,
    output logic                req_done,
    output logic                cmd_valid,
    output logic                cmd_is_stop,
    output logic [CMD_W-1:0]    cmd_index,
    output logic                rx_start,
    output logic                tx_start
);
    fsm_e state;
    logic op_write;
    logic op_flush;
    logic blk_done;

    // Done indication from the mover that serves the current direction.
    always_comb begin
        blk_done = op_write ? tx_done : rx_done;
    end

    // State, session and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            session     <= SESS_NONE;
            last_sector <= '0;
            op_sector   <= '0;
            op_hc       <= 1'b0;
            op_write    <= 1'b0;
            op_flush    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (flush_req) begin
                        op_flush <= 1'b1;
                        state    <= (session != SESS_NONE) ? ST_STOP : ST_DONE;
                    end else if (req_valid) begin
                        op_flush  <= 1'b0;
                        op_write  <= req_write;
                        op_sector <= req_sector;
                        op_hc     <= card_hc;
                        if (hit)
                            state <= ST_XGO;
                        else if (session != SESS_NONE)
                            state <= ST_STOP;
                        else
                            state <= ST_OPEN;
                    end
                end
                ST_STOP: begin
                    if (cmd_ack) begin
                        session <= SESS_NONE;
                        state   <= op_flush ? ST_DONE : ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (cmd_ack) begin
                        session <= op_write ? SESS_WRITE : SESS_READ;
                        state   <= ST_XGO;
                    end
                end
                ST_XGO: begin
                    state <= ST_XWAIT;
                end
                ST_XWAIT: begin
                    if (blk_done) begin
                        last_sector <= op_sector;
                        state       <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Moore outputs decoded from the state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        req_done    = (state == ST_DONE);
        cmd_is_stop = (state == ST_STOP);
        cmd_valid   = (state == ST_STOP) || (state == ST_OPEN);
        cmd_index   = cmd_is_stop ? CMD_STOP : (op_write ? CMD_WR_MULTI : CMD_RD_MULTI);
        rx_start    = (state == ST_XGO) && !op_write;
        tx_start    = (state == ST_XGO) && op_write;
    end
endmodule

// File: rtl/sdx_session_ctrl.sv
// Top of the SD multi-block session controller. Joins the sequencer,
// the reuse matcher and the address mapper, and forms the command
// argument and fixed tail byte. Assumes one request in flight.
module sdx_session_ctrl
    import sdx_pkg::*;
#(
    parameter int SECTOR_W    = 32,
    parameter int BLOCK_SHIFT = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [SECTOR_W-1:0] req_sector,
    input  logic                card_hc,
    input  logic                flush_req,
    output logic                req_ready,
    output logic                req_done,
    output logic                cmd_valid,
    output logic [CMD_W-1:0]    cmd_index,
    output logic [SECTOR_W-1:0] cmd_arg,
    output logic [7:0]          cmd_tail,
    input  logic                cmd_ack,
    output logic                rx_start,
    input  logic                rx_done,
    output logic                tx_start,
    input  logic                tx_done
);
    sess_e               session;
    logic [SECTOR_W-1:0] last_sector;
    logic [SECTOR_W-1:0] op_sector;
    logic                op_hc;
    logic                hit;
    logic                cmd_is_stop;
    logic [SECTOR_W-1:0] mapped_arg;

    sdx_seq_match #(.SECTOR_W(SECTOR_W)) u_match (
        .session     (session),
        .req_write   (req_write),
        .req_sector  (req_sector),
        .last_sector (last_sector),
        .hit         (hit)
    );

    sdx_addr_map #(.SECTOR_W(SECTOR_W), .BLOCK_SHIFT(BLOCK_SHIFT)) u_map (
        .sector (op_sector),
        .hc     (op_hc),
        .arg    (mapped_arg)
    );

    sdx_session_fsm #(.SECTOR_W(SECTOR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_sector  (req_sector),
        .card_hc     (card_hc),
        .flush_req   (flush_req),
        .hit         (hit),
        .cmd_ack     (cmd_ack),
        .rx_done     (rx_done),
        .tx_done     (tx_done),
        .session     (session),
        .last_sector (last_sector),
        .op_sector   (op_sector),
        .op_hc       (op_hc),
        .req_ready   (req_ready),
        .req_done    (req_done),
        .cmd_valid   (cmd_valid),
        .cmd_is_stop (cmd_is_stop),
        .cmd_index   (cmd_index),
        .rx_start    (rx_start),
        .tx_start    (tx_start)
    );

    // Stop carries a zero argument and fixed tail; open carries the address.
    always_comb begin
        cmd_arg  = cmd_is_stop ? '0 : mapped_arg;
        cmd_tail = cmd_is_stop ? STOP_TAIL : 8'h00;
    end
endmodule

// File: rtl/sdx_session_chk.sv
// Protocol checker for sdx_session_ctrl, attached by bind below.
// Assumes cmd_ack only while cmd_valid and done pulses only after starts.
module sdx_session_chk #(
    parameter int SECTOR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                req_done,
    input logic                cmd_valid,
    input logic [5:0]          cmd_index,
    input logic [SECTOR_W-1:0] cmd_arg,
    input logic [7:0]          cmd_tail,
    input logic                cmd_ack,
    input logic                rx_start,
    input logic                tx_start
);
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg)); // R10

    AST_STOP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd12 |-> cmd_arg == '0 && cmd_tail == 8'h61); // R6

    AST_OPEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index != 6'd12 |-> cmd_tail == 8'h00); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid && !rx_start && !tx_start && !req_done); // R8

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rx_start, tx_start, req_done})); // R8

    AST_DONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> req_ready); // R8

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start || tx_start |=> !rx_start && !tx_start); // R2

    AST_RD_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start && $past(cmd_valid) |-> $past(cmd_index) == 6'd18); // R2

    AST_WR_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && $past(cmd_valid) |-> $past(cmd_index) == 6'd25); // R5
endmodule

bind sdx_session_ctrl sdx_session_chk #(.SECTOR_W(SECTOR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_done  (req_done),
    .cmd_valid (cmd_valid),
    .cmd_index (cmd_index),
    .cmd_arg   (cmd_arg),
    .cmd_tail  (cmd_tail),
    .cmd_ack   (cmd_ack),
    .rx_start  (rx_start),
    .tx_start  (tx_start)
);

// File: tb/sdx_session_ctrl_tb.sv
`timescale 1ns/1ps
module sdx_session_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, card_hc = 1'b0, flush_req = 1'b0;
    logic [31:0] req_sector = '0;
    logic        req_ready, req_done, cmd_valid, rx_start, tx_start;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_tail;
    logic        cmd_ack = 1'b0, rx_done = 1'b0, tx_done = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sdx_session_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sector(req_sector), .card_hc(card_hc), .flush_req(flush_req),
        .req_ready(req_ready), .req_done(req_done), .cmd_valid(cmd_valid),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_tail(cmd_tail),
        .cmd_ack(cmd_ack), .rx_start(rx_start), .rx_done(rx_done),
        .tx_start(tx_start), .tx_done(tx_done)
    );

    typedef struct packed {
        logic        flush;
        logic        wr;
        logic        hc;
        logic [31:0] sec;
        logic        stop;
        logic [5:0]  open;
        logic [31:0] arg;
        logic [1:0]  nrx;
        logic [1:0]  ntx;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 32'd10,         1'b0, 6'd18, 32'h0000_1400, 2'd1, 2'd0}, // R2 R7
        '{1'b0, 1'b0, 1'b0, 32'd11,         1'b0, 6'd0,  32'h0,         2'd1, 2'd0}, // R3
        '{1'b0, 1'b0, 1'b0, 32'd12,         1'b0, 6'd0,  32'h0,         2'd1, 2'd0}, // R3 R11
        '{1'b0, 1'b0, 1'b0, 32'd20,         1'b1, 6'd18, 32'h0000_2800, 2'd1, 2'd0}, // R6
        '{1'b0, 1'b1, 1'b0, 32'd21,         1'b1, 6'd25, 32'h0000_2A00, 2'd0, 2'd1}, // R5 R6
        '{1'b0, 1'b1, 1'b0, 32'd22,         1'b0, 6'd0,  32'h0,         2'd0, 2'd1}, // R4
        '{1'b0, 1'b1, 1'b1, 32'h1234_5678,  1'b1, 6'd25, 32'h1234_5678, 2'd0, 2'd1}, // R7
        '{1'b0, 1'b0, 1'b1, 32'h1234_5679,  1'b1, 6'd18, 32'h1234_5679, 2'd1, 2'd0}, // R6
        '{1'b1, 1'b0, 1'b0, 32'h0,          1'b1, 6'd0,  32'h0,         2'd0, 2'd0}, // R9
        '{1'b0, 1'b0, 1'b0, 32'h1234_567A,  1'b0, 6'd18, 32'h68AC_F400, 2'd1, 2'd0}, // R9 R7
        '{1'b1, 1'b0, 1'b0, 32'h0,          1'b1, 6'd0,  32'h0,         2'd0, 2'd0}, // R9
        '{1'b1, 1'b0, 1'b0, 32'h0,          1'b0, 6'd0,  32'h0,         2'd0, 2'd0}, // R9
        '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF,  1'b0, 6'd25, 32'hFFFF_FE00, 2'd0, 2'd1}, // R7
        '{1'b0, 1'b1, 1'b0, 32'h0,          1'b0, 6'd0,  32'h0,         2'd0, 2'd1}  // R11
    };

    // Observations of one operation.
    int          g_ncmd, g_nrx, g_ntx;
    logic [5:0]  g_idx [4];
    logic [31:0] g_arg [4];
    logic [7:0]  g_tail [4];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request or flush with a responder model for the lower layers.
    task automatic run_op(input logic fl, input logic wr, input logic hc,
                          input logic [31:0] sec, input logic noise);
        logic        seen = 1'b0;
        logic        rxp = 1'b0, txp = 1'b0;
        int          waitc = 0;
        logic [5:0]  hold_idx = '0;
        logic [31:0] hold_arg = '0;
        g_ncmd = 0; g_nrx = 0; g_ntx = 0;
        chk(req_ready, "R8 ready before request", {31'b0, req_ready}, 32'd1);
        flush_req = fl; req_valid = !fl; req_write = wr; card_hc = hc; req_sector = sec;
        @(posedge clk); @(negedge clk);
        flush_req = 1'b0;
        if (noise) req_sector = sec + 32'd1;
        else req_valid = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (cmd_ack) begin cmd_ack = 1'b0; seen = 1'b0; end
            if (rx_done) rx_done = 1'b0;
            if (tx_done) tx_done = 1'b0;
            if (req_done) break;
            if (req_ready) chk(1'b0, "R8 ready during operation", 32'd1, 32'd0);
            if (cmd_valid) begin
                if (!seen) begin
                    seen = 1'b1; waitc = 0; hold_idx = cmd_index; hold_arg = cmd_arg;
                    if (g_ncmd < 4) begin
                        g_idx[g_ncmd] = cmd_index; g_arg[g_ncmd] = cmd_arg; g_tail[g_ncmd] = cmd_tail;
                    end
                    g_ncmd++;
                end else begin
                    chk(cmd_index == hold_idx && cmd_arg == hold_arg, "R10 command held",
                        cmd_arg, hold_arg);
                end
                waitc++;
                if (waitc == 3) cmd_ack = 1'b1;
            end
            if (rx_start) begin g_nrx++; rxp = 1'b1; end
            else if (rxp) begin rx_done = 1'b1; rxp = 1'b0; end
            if (tx_start) begin g_ntx++; txp = 1'b1; end
            else if (txp) begin tx_done = 1'b1; txp = 1'b0; end
            @(posedge clk); @(negedge clk);
        end
        chk(req_done, "R8 operation completes", {31'b0, req_done}, 32'd1);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk_vec(input vec_t v, input int i);
        int exp_n;
        int p;
        exp_n = int'(v.stop) + ((v.open != 6'd0) ? 1 : 0);
        chk(g_ncmd == exp_n, $sformatf("vector %0d command count", i), g_ncmd, exp_n);
        if (g_ncmd == exp_n) begin
            if (v.stop) begin
                chk(g_idx[0] == 6'd12 && g_arg[0] == 32'd0 && g_tail[0] == 8'h61,
                    $sformatf("R6 vector %0d stop form", i), {g_idx[0], g_arg[0][17:0], g_tail[0]}, 32'h0);
            end
            if (v.open != 6'd0) begin
                p = v.stop ? 1 : 0;
                chk(g_idx[p] == v.open, $sformatf("R2/R5 vector %0d open index", i), g_idx[p], v.open);
                chk(g_arg[p] == v.arg, $sformatf("R7 vector %0d open argument", i), g_arg[p], v.arg);
                chk(g_tail[p] == 8'h00, $sformatf("R7 vector %0d open tail", i), g_tail[p], 32'h0);
            end
        end
        chk(g_nrx == int'(v.nrx), $sformatf("vector %0d rx blocks", i), g_nrx, v.nrx);
        chk(g_ntx == int'(v.ntx), $sformatf("vector %0d tx blocks", i), g_ntx, v.ntx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !cmd_valid && !rx_start && !tx_start && !req_done, "R1 reset outputs",
            {27'b0, req_ready, cmd_valid, rx_start, tx_start, req_done}, 32'h10);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(req_ready && !cmd_valid, "R1 first cycle after reset", {30'b0, req_ready, cmd_valid}, 32'h2);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].flush, VEC[i].wr, VEC[i].hc, VEC[i].sec, 1'b0);
            chk_vec(VEC[i], i);
        end

        // R1: reset drops the open write; consecutive sector must reopen.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        run_op(1'b0, 1'b1, 1'b0, 32'd1, 1'b0);
        chk(g_ncmd == 1 && g_idx[0] == 6'd25, "R1 no session after reset", g_ncmd, 32'd1);

        // R8: a request held during a busy operation is ignored.
        run_op(1'b0, 1'b0, 1'b0, 32'd1, 1'b1);
        chk(g_ncmd == 2, "R8 direction change with busy noise", g_ncmd, 32'd2);
        chk(req_ready && !cmd_valid, "R8 idle after ignored request", {30'b0, req_ready, cmd_valid}, 32'h2);
        run_op(1'b0, 1'b0, 1'b0, 32'd2, 1'b0);
        chk(g_ncmd == 0 && g_nrx == 1, "R8 R3 last sector unaffected by noise", g_ncmd, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule